// File: doc/BRIEF.md
# PLL Power and Clock-Gate Sequencer

This block sits between a PLL's analog macro and the rest of the clock tree. It decides when the PLL is powered down and when the PLL output clock is allowed through the gate. In software mode two register bits drive those two controls directly. In hardware mode the block follows a system-level enable and answers with a response signal. Power-down follows a delayed copy of the enable. The clock gate opens only once the synchronized analog lock is seen and a programmed lock-wait count has elapsed.

When hardware mode and change mode are both active, a strobe carrying a new feedback divider and fractional value does not reach the PLL at once. The block first closes the clock gate and then powers the PLL down for a fixed minimum time. It loads the new values while the PLL is still down, then releases power-down, waits out the lock time again and reopens the gate. The response to the system stays high for the whole sequence. A strobe that arrives while a sequence is running is remembered, and a second sequence follows once the first one finishes. The output frequency is Fref/refdiv*(fbdiv + frac/2^24)/postdiv, so a frac of 0x800000 adds one half to the multiplier.

Top module: `pll_seq_top`

## Requirements
- R1: With hwEn low, pllPd equals swPd and pllClkEn equals swClkEn in the same cycle, whatever the system enable and the lock are doing.
- R2: With hwEn high, pllPd is high when a change sequence holds power-down, or when the system enable seen SOC_DLY (default 2) clock edges earlier was low. After socEnable rises, pllPd falls SOC_DLY edges later.
- R3: With hwEn high, pllClkEn is high only while socEnable is high, the raw lock has passed a two-flop synchronizer, and the sequencer is not gating the clock. The clock opens exactly lockWaitCycles edges after pllPd falls, and the value 0 leaves only the synchronizer delay.
- R4: response rises on the edge after pllClkEn is high together with socEnable. It falls only on an edge where socEnable is low and pllPd is high. The PLL is off when socEnable and response are both 0.
- R5: A change sequence closes the clock gate one cycle before power-down rises. It then holds power-down for PD_HOLD+2 cycles (default 6) and reopens the clock exactly lockWaitCycles+1 cycles after power-down falls.
- R6: response stays high from the strobe to the end of a change sequence while socEnable stays high.
- R7: With change mode off (or hwEn low), a strobe copies newFbdiv and newFrac to the applied outputs on the next edge, and pllPd is not raised.
- R8: A strobe during a running sequence causes exactly one more complete sequence. The applied values end as those of the last strobe.
- R9: With hwEn and change mode on, the applied values change only on the edge leaving the load step, while pllPd is high.
- R10: After reset, in hardware mode, pllPd is 1, pllClkEn and response are 0, fbdivApplied is DEF_FBDIV (default 40) and fracApplied is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hwEn | input | 1 | 1: hardware-controlled mode, 0: software mode |
| chgMode | input | 1 | 1: parameter updates run the power-cycle sequence |
| swPd | input | 1 | Software power-down bit |
| swClkEn | input | 1 | Software clock-enable bit |
| socEnable | input | 1 | System-level PLL enable |
| pllLockRaw | input | 1 | Asynchronous lock from the analog PLL |
| lockWaitCycles | input | 16 | Lock wait in reference clock cycles |
| updStrobe | input | 1 | One-cycle strobe: new divider values are valid |
| newFbdiv | input | 12 | New feedback divider |
| newFrac | input | 24 | New fractional value |
| pllPd | output | 1 | Power-down to the analog PLL |
| pllClkEn | output | 1 | Output clock gate enable |
| response | output | 1 | Response to the system enable |
| fbdivApplied | output | 12 | Feedback divider presented to the PLL |
| fracApplied | output | 24 | Fractional value presented to the PLL |

## Verification
A sequencer stuck in or skipping a step shows at the ports within one cycle. The clock gate either stays open when power-down rises, or power-down stays high for the wrong number of cycles. A wrong lock counter moves the edge where the clock gate reopens, and the bench measures that distance in exact cycles, with and without a zero wait. A lost pending flag shows as one power-down pulse where two are expected, and stale divider values show in the applied outputs as soon as the sequence ends.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GATE,
    SQ_DOWN,
    SQ_LOAD,
    SQ_SETTLE,
    SQ_WAIT,
    SQ_ENABLE
  } seqState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadParams;
    logic chgPd;
    logic chgClkEn;
  } seqStb_t;

endpackage

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int PD_HOLD = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    seqArm,
  input  logic    updStrobe,
  input  logic    lockComb,
  output seqStb_t stb
);

  localparam int HW = (PD_HOLD < 2) ? 1 : $clog2(PD_HOLD);
  localparam logic [HW-1:0] HOLD_LAST = HW'(PD_HOLD - 1);

  seqState_e state, nxt;
  logic [HW-1:0] holdCnt;
  logic pending;
  logic trigger;

  assign trigger = seqArm & (updStrobe | pending);

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_IDLE:   if (trigger) nxt = SQ_GATE;
      SQ_GATE:   nxt = SQ_DOWN;
      SQ_DOWN:   if (holdCnt == HOLD_LAST) nxt = SQ_LOAD;
      SQ_LOAD:   nxt = SQ_SETTLE;
      SQ_SETTLE: nxt = SQ_WAIT;
      SQ_WAIT:   if (lockComb) nxt = SQ_ENABLE;
      SQ_ENABLE: nxt = SQ_IDLE;
      default:   nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      holdCnt <= '0;
      pending <= 1'b0;
    end else begin
      state <= nxt;
      if (state == SQ_DOWN) holdCnt <= holdCnt + 1'b1;
      else                  holdCnt <= '0;
      if (state == SQ_IDLE && trigger)
        pending <= 1'b0;
      else if (state != SQ_IDLE && updStrobe && seqArm)
        pending <= 1'b1;
    end
  end

  always_comb begin
    stb.loadParams = (state == SQ_LOAD);
    stb.chgPd      = (state == SQ_DOWN) || (state == SQ_LOAD) || (state == SQ_SETTLE);
    stb.chgClkEn   = (state == SQ_IDLE) || (state == SQ_ENABLE);
  end

endmodule

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int           SOC_DLY   = 2,
  parameter int           LOCKW     = 16,
  parameter int           FBW       = 12,
  parameter int           FRACW     = 24,
  parameter logic [11:0]  DEF_FBDIV = 12'd40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hwEn,
  input  logic             seqArm,
  input  logic             swPd,
  input  logic             swClkEn,
  input  logic             socEnable,
  input  logic             pllLockRaw,
  input  logic [LOCKW-1:0] lockWaitCycles,
  input  logic             updStrobe,
  input  logic [FBW-1:0]   newFbdiv,
  input  logic [FRACW-1:0] newFrac,
  input  seqStb_t          stb,
  output logic             lockComb,
  output logic             pllPd,
  output logic             pllClkEn,
  output logic             response,
  output logic [FBW-1:0]   fbdivApplied,
  output logic [FRACW-1:0] fracApplied
);

  logic socOn;
  logic [1:0] lockSync;
  logic [LOCKW-1:0] lockCnt;
  logic lockDone;
  logic [FBW-1:0]   shadowFbdiv;
  logic [FRACW-1:0] shadowFrac;

  // delayed copy of the system enable
  generate
    if (SOC_DLY == 0) begin : g_noDly
      assign socOn = socEnable;
    end else begin : g_dly
      logic [SOC_DLY-1:0] socPipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) socPipe <= '0;
        else        socPipe <= {socPipe[SOC_DLY-2 >= 0 ? SOC_DLY-2 : 0 : 0], socEnable} & {SOC_DLY{1'b1}};
      end
      assign socOn = socPipe[SOC_DLY-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lockSync <= '0;
    else        lockSync <= {lockSync[0], pllLockRaw};
  end

  assign lockDone = (lockCnt >= lockWaitCycles);
  assign lockComb = lockSync[1] & lockDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lockCnt <= '0;
    else if (pllPd)     lockCnt <= '0;
    else if (!lockDone) lockCnt <= lockCnt + 1'b1;
  end

  always_comb begin
    if (hwEn) begin
      pllPd    = ~socOn | stb.chgPd;
      pllClkEn = lockComb & socEnable & stb.chgClkEn;
    end else begin
      pllPd    = swPd;
      pllClkEn = swClkEn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      response <= 1'b0;
    else if (socEnable && pllClkEn)  response <= 1'b1;
    else if (!socEnable && pllPd)    response <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowFbdiv  <= DEF_FBDIV[FBW-1:0];
      shadowFrac   <= '0;
      fbdivApplied <= DEF_FBDIV[FBW-1:0];
      fracApplied  <= '0;
    end else begin
      if (updStrobe) begin
        shadowFbdiv <= newFbdiv;
        shadowFrac  <= newFrac;
      end
      if (updStrobe && !seqArm) begin
        fbdivApplied <= newFbdiv;
        fracApplied  <= newFrac;
      end else if (stb.loadParams) begin
        fbdivApplied <= shadowFbdiv;
        fracApplied  <= shadowFrac;
      end
    end
  end

endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
  import pll_seq_pkg::*;
#(
  parameter int          SOC_DLY   = 2,
  parameter int          PD_HOLD   = 4,
  parameter int          LOCKW     = 16,
  parameter int          FBW       = 12,
  parameter int          FRACW     = 24,
  parameter logic [11:0] DEF_FBDIV = 12'd40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hwEn,
  input  logic             chgMode,
  input  logic             swPd,
  input  logic             swClkEn,
  input  logic             socEnable,
  input  logic             pllLockRaw,
  input  logic [LOCKW-1:0] lockWaitCycles,
  input  logic             updStrobe,
  input  logic [FBW-1:0]   newFbdiv,
  input  logic [FRACW-1:0] newFrac,
  output logic             pllPd,
  output logic             pllClkEn,
  output logic             response,
  output logic [FBW-1:0]   fbdivApplied,
  output logic [FRACW-1:0] fracApplied
);

  seqStb_t seqStb;
  logic    seqArm;
  logic    lockComb;

  assign seqArm = hwEn & chgMode;

  pll_seq_ctrl #(.PD_HOLD(PD_HOLD)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .seqArm    (seqArm),
    .updStrobe (updStrobe),
    .lockComb  (lockComb),
    .stb       (seqStb)
  );

  pll_seq_dp #(
    .SOC_DLY   (SOC_DLY),
    .LOCKW     (LOCKW),
    .FBW       (FBW),
    .FRACW     (FRACW),
    .DEF_FBDIV (DEF_FBDIV)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .hwEn           (hwEn),
    .seqArm         (seqArm),
    .swPd           (swPd),
    .swClkEn        (swClkEn),
    .socEnable      (socEnable),
    .pllLockRaw     (pllLockRaw),
    .lockWaitCycles (lockWaitCycles),
    .updStrobe      (updStrobe),
    .newFbdiv       (newFbdiv),
    .newFrac        (newFrac),
    .stb            (seqStb),
    .lockComb       (lockComb),
    .pllPd          (pllPd),
    .pllClkEn       (pllClkEn),
    .response       (response),
    .fbdivApplied   (fbdivApplied),
    .fracApplied    (fracApplied)
  );

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk
  import pll_seq_pkg::*;
#(
  parameter int PD_HOLD = 4,
  parameter int FBW     = 12,
  parameter int FRACW   = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hwEn,
  input logic             chgMode,
  input logic             swPd,
  input logic             swClkEn,
  input logic             socEnable,
  input logic             pllPd,
  input logic             pllClkEn,
  input logic             response,
  input logic [FBW-1:0]   fbdivApplied,
  input logic [FRACW-1:0] fracApplied,
  input seqStb_t          seqStb
);

  logic [7:0] pdRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pdRun <= '0;
    else if (!seqStb.chgPd)             pdRun <= '0;
    else if (pdRun != 8'hFF)            pdRun <= pdRun + 1'b1;
  end

  AST_SW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !hwEn |-> (pllPd == swPd) && (pllClkEn == swClkEn)); // R1

  AST_SOC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    hwEn && !socEnable |-> !pllClkEn); // R3

  AST_GATE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    hwEn && seqStb.chgPd |-> !pllClkEn); // R5

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seqStb.chgPd) |-> pdRun >= 8'(PD_HOLD + 2)); // R5

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    response && socEnable |=> response); // R6

  AST_LOAD_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    hwEn && seqStb.loadParams |-> pllPd); // R9

  AST_APPLIED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    hwEn && chgMode && !seqStb.loadParams |=> $stable(fbdivApplied) && $stable(fracApplied)); // R9

endmodule

bind pll_seq_top pll_seq_chk #(
  .PD_HOLD (PD_HOLD),
  .FBW     (FBW),
  .FRACW   (FRACW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hwEn         (hwEn),
  .chgMode      (chgMode),
  .swPd         (swPd),
  .swClkEn      (swClkEn),
  .socEnable    (socEnable),
  .pllPd        (pllPd),
  .pllClkEn     (pllClkEn),
  .response     (response),
  .fbdivApplied (fbdivApplied),
  .fracApplied  (fracApplied),
  .seqStb       (seqStb)
);

// File: tb/sim_pll_seq_top.sv
`timescale 1ns/1ps
module sim_pll_seq_top;

  localparam int PDH = 4;
  localparam int SDL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hwEn = 1'b1, chgMode = 1'b1, swPd = 1'b0, swClkEn = 1'b0;
  logic socEnable = 1'b0, lockBlock = 1'b0, updStrobe = 1'b0;
  logic [15:0] lockWaitCycles = 16'd20;
  logic [11:0] newFbdiv = '0;
  logic [23:0] newFrac = '0;
  logic pllPd, pllClkEn, response, pllLockRaw;
  logic [11:0] fbdivApplied;
  logic [23:0] fracApplied;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  assign pllLockRaw = ~pllPd & ~lockBlock;

  pll_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .hwEn(hwEn), .chgMode(chgMode), .swPd(swPd),
    .swClkEn(swClkEn), .socEnable(socEnable), .pllLockRaw(pllLockRaw),
    .lockWaitCycles(lockWaitCycles), .updStrobe(updStrobe), .newFbdiv(newFbdiv),
    .newFrac(newFrac), .pllPd(pllPd), .pllClkEn(pllClkEn), .response(response),
    .fbdivApplied(fbdivApplied), .fracApplied(fracApplied)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 pd", pllPd, 1);
    chk("R10 clken", pllClkEn, 0);
    chk("R10 response", response, 0);
    chk("R10 fbdiv", fbdivApplied, 40);
    chk("R10 frac", fracApplied, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_swmode();
    hwEn = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      swPd = k[0]; swClkEn = k[1]; socEnable = k[0] ^ k[1];
      #1;
      chk("R1 pd", pllPd, k[0]);
      chk("R1 clken", pllClkEn, k[1]);
    end
    @(negedge clk);
    hwEn = 1'b1; socEnable = 1'b0; swPd = 1'b0; swClkEn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_powerup();
    int k, n;
    socEnable = 1'b1;
    k = 0;
    while (pllPd && k < 20) begin @(negedge clk); k++; end
    chk("R2 pd release delay", k, SDL);
    n = 0;
    while (!pllClkEn && n < 100) begin
      chk("R4 response low before clock", response, 0);
      @(negedge clk); n++;
    end
    chk("R3 lock wait", n, lockWaitCycles);
    @(negedge clk);
    chk("R4 response up", response, 1);
  endtask

  task automatic t_poweroff();
    socEnable = 1'b0;
    #1 chk("R3 clken drops with enable", pllClkEn, 0);
    @(negedge clk);
    chk("R2 pd still low", pllPd, 0);
    @(negedge clk);
    chk("R2 pd high after delay", pllPd, 1);
    @(negedge clk);
    chk("R4 response low -> off", response, 0);
  endtask

  task automatic t_lockblock();
    lockBlock = 1'b1; socEnable = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 no clock without lock", pllClkEn, 0);
    chk("R3 pd low", pllPd, 0);
    lockBlock = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 clock after lock", pllClkEn, 1);
    chk("R4 response after lock", response, 1);
  endtask

  task automatic t_change(input logic [11:0] fb, input logic [23:0] fr, input string tag);
    int gateIdx = -1, pdRise = -1, pdLen = 0, chgIdx = -1, reEn = -1, respLow = 0;
    newFbdiv = fb; newFrac = fr; updStrobe = 1'b1;
    for (int i = 1; i < 120; i++) begin
      @(negedge clk);
      updStrobe = 1'b0;
      if (!response) respLow = 1;
      if (gateIdx < 0 && !pllClkEn) gateIdx = i;
      if (pllPd) begin
        if (pdRise < 0) pdRise = i;
        pdLen++;
      end
      if (chgIdx < 0 && fbdivApplied == fb && pllPd) chgIdx = i;
      if (pdRise >= 0 && reEn < 0 && pllClkEn) reEn = i;
    end
    chk({tag, " R5 gate before pd"}, (gateIdx == pdRise - 1), 1);
    chk({tag, " R5 pd length"}, pdLen, PDH + 2);
    chk({tag, " R9 applied during pd"}, (chgIdx > pdRise && chgIdx < pdRise + pdLen), 1);
    chk({tag, " R5 reenable"}, reEn, pdRise + pdLen + ((lockWaitCycles == 0) ? 3 : lockWaitCycles + 1));
    chk({tag, " R6 response held"}, respLow, 0);
    chk({tag, " R9 fbdiv"}, fbdivApplied, fb);
    chk({tag, " R9 frac"}, fracApplied, fr);
  endtask

  task automatic t_double();
    int pulses = 0, respLow = 0;
    logic prevPd = 1'b0;
    for (int i = 0; i < 110; i++) begin
      if (i == 0) begin newFbdiv = 12'h0A1; newFrac = 24'h100000; updStrobe = 1'b1; end
      else if (i == 3) begin newFbdiv = 12'h0B2; newFrac = 24'h200000; updStrobe = 1'b1; end
      else updStrobe = 1'b0;
      @(negedge clk);
      if (!response) respLow = 1;
      if (pllPd && !prevPd) pulses++;
      prevPd = pllPd;
    end
    chk("R8 two sequences", pulses, 2);
    chk("R8 last fbdiv", fbdivApplied, 12'h0B2);
    chk("R8 last frac", fracApplied, 24'h200000);
    chk("R8 clock back", pllClkEn, 1);
    chk("R6 response held double", respLow, 0);
  endtask

  task automatic t_direct();
    chgMode = 1'b0;
    newFbdiv = 12'h123; newFrac = 24'h0ABCDE; updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
    chk("R7 fbdiv immediate", fbdivApplied, 12'h123);
    chk("R7 frac immediate", fracApplied, 24'h0ABCDE);
    for (int i = 0; i < 5; i++) begin
      chk("R7 no pd", pllPd, 0);
      chk("R7 clock kept", pllClkEn, 1);
      @(negedge clk);
    end
    chgMode = 1'b1;
  endtask

  initial begin
    t_reset();
    t_swmode();
    t_powerup();
    t_poweroff();
    t_lockblock();
    @(negedge clk);
    t_change(12'h055, 24'h800000, "seq");
    t_double();
    t_direct();
    lockWaitCycles = 16'd0;
    @(negedge clk);
    t_change(12'h0C4, 24'h000001, "zero-wait");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule